// File: doc/BRIEF.md
# DMA Bus-Cycle Timing Sequencer

This block is the timing and control engine of a byte-wide DMA controller. It waits while no unmasked channel wants service. Once a request arrives, it asks the host for the system bus and waits for the grant. It then drives one bus cycle per byte: an address phase followed by a strobe phase. This continues until the programmed length is used up or an external end-of-process input stops it. The channel number and the transfer parameters come from neighbouring blocks. A priority unit supplies the channel. The register file supplies the mode, the start address, the destination address, the length field and the address direction. All of these are sampled on the cycle the service starts.

Three transfer kinds are supported:
- **Memory to I/O:** the memory read strobe and the I/O write strobe fire together.
- **I/O to memory:** the I/O read strobe and the memory write strobe fire together.
- **Memory to memory:** the source byte is read into an internal holding register in one bus cycle and written to the destination in a second bus cycle.

In every kind, a slow device applies back-pressure by holding `rdy` low. The current strobe then stays asserted, and nothing advances, until `rdy` is sampled high. Tri-state pads are modelled as separate output-enable pins.

The upper half of the address is multiplexed onto the data pins and captured by an external latch. The sequencer strobes it only when the latch content would change.

Top module: `dma_cycle_seq`

## Requirements
- R1: While `svc_req` is low, or `svc_mode` is 0 (no transfer), the sequencer stays idle and `hold_req` stays low.
- R2: A request with `svc_mode` in {1,2,3} raises `hold_req` on the next cycle. The first address cycle starts only after `hold_ack` has been sampled high at a rising edge. `hold_req` stays high until the service ends.
- R3: Outside the address and strobe cycles, `aen`, `addr_oe` and `data_oe` are low, `dack` is zero, `addr_lo` is zero and all four strobes are high.
- R4: Mode 1 (memory to I/O): each byte takes one address cycle (`aen`, `addr_oe`, `dack[svc_chan]` high) and then at least one strobe cycle with `memr_n` and `iow_n` both low and `dack[svc_chan]` high.
- R5: Mode 2 (I/O to memory): the strobe cycle drives `ior_n` and `memw_n` low together, with the same address cycle and `dack` behaviour as R4.
- R6: Mode 3 (memory to memory): a read cycle at the source address (`memr_n` low) captures `data_in` at the rising edge that ends it. A write cycle at the destination address follows (`memw_n` low, `data_oe` high, `data_out` equal to the captured byte). `dack` stays zero throughout.
- R7: When `rdy` is low at the rising edge that ends a strobe cycle, that strobe cycle repeats unchanged.
- R8: `adstb` is high in an address cycle exactly when it is the first address cycle of the service, or when the upper address byte differs from the one last strobed. During that cycle `data_oe` is high and `data_out` carries the upper address byte.
- R9: `addr_lo` shows the low address byte during address and strobe cycles. After each completed byte, both addresses step by +1 (`addr_dec`=0) or by -1 (`addr_dec`=1), modulo 2^16. A length field of N moves N+1 bytes.
- R10: After the last byte's strobe completes, the next cycle is idle with `hold_req` low, and `tc_n` is low for exactly that one cycle.
- R11: `eop_in_n` low at a rising edge during an address or strobe cycle makes the next cycle idle, with no `tc_n` pulse. While idle or waiting for the grant, `eop_in_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| svc_req | input | 1 | Service wanted on an unmasked channel |
| svc_chan | input | 2 | Winning channel number |
| svc_mode | input | 2 | 0 none, 1 memory to I/O, 2 I/O to memory, 3 memory to memory |
| addr_dec | input | 1 | 1: addresses count down |
| base_addr | input | 16 | Memory address (source for mode 3) |
| dest_addr | input | 16 | Destination address for mode 3 |
| xfer_len | input | 16 | Bytes to move minus one |
| hold_ack | input | 1 | Host has released the bus |
| rdy | input | 1 | Low stretches the strobe cycle |
| eop_in_n | input | 1 | External end of process, active low |
| data_in | input | 8 | Data pins, inbound |
| hold_req | output | 1 | Bus request to host |
| aen | output | 1 | Address enable for the upper-byte latch path |
| adstb | output | 1 | Upper-byte latch strobe |
| addr_oe | output | 1 | Output enable of the low address pins |
| addr_lo | output | 8 | Low address byte |
| data_oe | output | 1 | Output enable of the data pins |
| data_out | output | 8 | Data pins, outbound |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| dack | output | 4 | Per-channel acknowledge, active high |
| tc_n | output | 1 | Terminal count pulse, active low |

## Verification
The hardest case to reach is a re-strobe of the upper address byte in the middle of a service. The low address must wrap across a 256-byte boundary, in either direction. In memory-to-memory mode, the source and destination upper bytes alternate. The stimulus starts one service at 0x12FE counting up over four bytes, and another at 0x2001 counting down. It runs a memory-to-memory copy between pages 0x40 and 0x50, so that `adstb` fires on every address cycle. Wait states are placed inside strobes, and an end-of-process pulse is sent both during the grant wait and in the middle of a transfer. A behavioural reference model predicts every output on every cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_ADDR, ST_STRB} seq_state_e;
  typedef enum logic [1:0] {XF_NONE, XF_M2IO, XF_IO2M, XF_M2M} xfer_mode_e;
endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            svc_req,
  input  logic [CW-1:0]   svc_chan,
  input  logic [1:0]      svc_mode,
  input  logic            hold_ack,
  input  logic            rdy,
  input  logic            eop_in_n,
  input  logic            last_byte,
  output seq_state_e      state,
  output xfer_mode_e      mode_q,
  output logic [CW-1:0]   chan_q,
  output logic            wr_phase,
  output logic            tc_flag,
  output logic            load,
  output logic            capture,
  output logic            byte_done
);
  logic start, strobe_done;

  assign start       = (state == ST_IDLE) && svc_req && (svc_mode != 2'd0);
  assign load        = start;
  assign strobe_done = (state == ST_STRB) && eop_in_n && rdy;
  assign capture     = strobe_done && (mode_q == XF_M2M) && !wr_phase;
  assign byte_done   = strobe_done && !capture;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_q   <= XF_NONE;
      chan_q   <= '0;
      wr_phase <= 1'b0;
      tc_flag  <= 1'b0;
    end else begin
      tc_flag <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_HOLD;
          mode_q   <= xfer_mode_e'(svc_mode);
          chan_q   <= svc_chan;
          wr_phase <= 1'b0;
        end
        ST_HOLD: if (hold_ack) state <= ST_ADDR;
        ST_ADDR: state <= eop_in_n ? ST_STRB : ST_IDLE;
        ST_STRB: begin
          if (!eop_in_n) begin
            state <= ST_IDLE;
          end else if (rdy) begin
            if (capture) begin
              wr_phase <= 1'b1;
              state    <= ST_ADDR;
            end else begin
              wr_phase <= 1'b0;
              if (last_byte) begin
                state   <= ST_IDLE;
                tc_flag <= 1'b1;
              end else begin
                state <= ST_ADDR;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
  parameter int AW = 16,
  parameter int LW = AW / 2,
  localparam int HW = AW - LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] dest_addr,
  input  logic [AW-1:0] xfer_len,
  input  logic          addr_dec,
  input  logic          byte_done,
  input  logic          in_addr,
  input  logic          use_dest,
  output logic [AW-1:0] cur_addr,
  output logic          last_byte,
  output logic          adstb
);
  logic [AW-1:0] base_q, dest_q, rem_q;
  logic          dec_q, upv_q;
  logic [HW-1:0] up_q;
  logic          hi_differs;

  function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a, input logic dn);
    return dn ? a - AW'(1) : a + AW'(1);
  endfunction

  assign cur_addr   = use_dest ? dest_q : base_q;
  assign last_byte  = (rem_q == '0);
  assign hi_differs = !upv_q || (cur_addr[AW-1:LW] != up_q);
  assign adstb      = in_addr && hi_differs;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      dest_q <= '0;
      rem_q  <= '0;
      dec_q  <= 1'b0;
      upv_q  <= 1'b0;
      up_q   <= '0;
    end else if (load) begin
      base_q <= base_addr;
      dest_q <= dest_addr;
      rem_q  <= xfer_len;
      dec_q  <= addr_dec;
      upv_q  <= 1'b0;
    end else begin
      if (adstb) begin
        up_q  <= cur_addr[AW-1:LW];
        upv_q <= 1'b1;
      end
      if (byte_done && !last_byte) begin
        rem_q  <= rem_q - AW'(1);
        base_q <= stepped(base_q, dec_q);
        dest_q <= stepped(dest_q, dec_q);
      end
    end
  end
endmodule

// File: rtl/dma_seq_drive.sv
module dma_seq_drive
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int LW  = AW / 2,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  seq_state_e      state,
  input  xfer_mode_e      mode_q,
  input  logic [CW-1:0]   chan_q,
  input  logic            wr_phase,
  input  logic            capture,
  input  logic            tc_flag,
  input  logic [DW-1:0]   data_in,
  input  logic [AW-1:0]   cur_addr,
  input  logic            adstb_in,
  output logic            hold_req,
  output logic            aen,
  output logic            adstb,
  output logic            addr_oe,
  output logic [LW-1:0]   addr_lo,
  output logic            data_oe,
  output logic [DW-1:0]   data_out,
  output logic            memr_n,
  output logic            memw_n,
  output logic            ior_n,
  output logic            iow_n,
  output logic [NCH-1:0]  dack,
  output logic            tc_n
);
  logic [DW-1:0] temp_q;
  logic active, strobing, m2m_wr, dack_en;

  always_ff @(posedge clk) begin
    if (rst)          temp_q <= '0;
    else if (capture) temp_q <= data_in;
  end

  assign active   = (state == ST_ADDR) || (state == ST_STRB);
  assign strobing = (state == ST_STRB);
  assign m2m_wr   = strobing && (mode_q == XF_M2M) && wr_phase;
  assign dack_en  = active && (mode_q != XF_M2M);

  assign hold_req = (state != ST_IDLE);
  assign aen      = active;
  assign addr_oe  = active;
  assign adstb    = adstb_in;
  assign addr_lo  = active ? cur_addr[LW-1:0] : '0;
  assign data_oe  = adstb_in || m2m_wr;
  assign data_out = adstb_in ? DW'(cur_addr[AW-1:LW]) : (m2m_wr ? temp_q : '0);
  assign memr_n   = !(strobing && ((mode_q == XF_M2IO) || ((mode_q == XF_M2M) && !wr_phase)));
  assign memw_n   = !(strobing && ((mode_q == XF_IO2M) || m2m_wr));
  assign ior_n    = !(strobing && (mode_q == XF_IO2M));
  assign iow_n    = !(strobing && (mode_q == XF_M2IO));
  assign tc_n     = !tc_flag;

  for (genvar g = 0; g < NCH; g++) begin : g_dack
    assign dack[g] = dack_en && (chan_q == CW'(g));
  end
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH),
  localparam int LW = AW / 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           svc_req,
  input  logic [CW-1:0]  svc_chan,
  input  logic [1:0]     svc_mode,
  input  logic           addr_dec,
  input  logic [AW-1:0]  base_addr,
  input  logic [AW-1:0]  dest_addr,
  input  logic [AW-1:0]  xfer_len,
  input  logic           hold_ack,
  input  logic           rdy,
  input  logic           eop_in_n,
  input  logic [DW-1:0]  data_in,
  output logic           hold_req,
  output logic           aen,
  output logic           adstb,
  output logic           addr_oe,
  output logic [LW-1:0]  addr_lo,
  output logic           data_oe,
  output logic [DW-1:0]  data_out,
  output logic           memr_n,
  output logic           memw_n,
  output logic           ior_n,
  output logic           iow_n,
  output logic [NCH-1:0] dack,
  output logic           tc_n
);
  seq_state_e    state;
  xfer_mode_e    mode_q;
  logic [CW-1:0] chan_q;
  logic          wr_phase, tc_flag, load, capture, byte_done, last_byte, adstb_w;
  logic [AW-1:0] cur_addr;

  dma_seq_fsm #(.NCH(NCH)) u_fsm (
    .clk(clk), .rst(rst), .svc_req(svc_req), .svc_chan(svc_chan), .svc_mode(svc_mode),
    .hold_ack(hold_ack), .rdy(rdy), .eop_in_n(eop_in_n), .last_byte(last_byte),
    .state(state), .mode_q(mode_q), .chan_q(chan_q), .wr_phase(wr_phase),
    .tc_flag(tc_flag), .load(load), .capture(capture), .byte_done(byte_done)
  );

  dma_seq_addr #(.AW(AW), .LW(LW)) u_addr (
    .clk(clk), .rst(rst), .load(load), .base_addr(base_addr), .dest_addr(dest_addr),
    .xfer_len(xfer_len), .addr_dec(addr_dec), .byte_done(byte_done),
    .in_addr(state == ST_ADDR), .use_dest((mode_q == XF_M2M) && wr_phase),
    .cur_addr(cur_addr), .last_byte(last_byte), .adstb(adstb_w)
  );

  dma_seq_drive #(.NCH(NCH), .AW(AW), .LW(LW), .DW(DW)) u_drive (
    .clk(clk), .rst(rst), .state(state), .mode_q(mode_q), .chan_q(chan_q),
    .wr_phase(wr_phase), .capture(capture), .tc_flag(tc_flag), .data_in(data_in),
    .cur_addr(cur_addr), .adstb_in(adstb_w), .hold_req(hold_req), .aen(aen),
    .adstb(adstb), .addr_oe(addr_oe), .addr_lo(addr_lo), .data_oe(data_oe),
    .data_out(data_out), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n),
    .iow_n(iow_n), .dack(dack), .tc_n(tc_n)
  );
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           hold_ack,
  input logic           rdy,
  input logic           eop_in_n,
  input logic           hold_req,
  input logic           aen,
  input logic           adstb,
  input logic           addr_oe,
  input logic           data_oe,
  input logic           memr_n,
  input logic           memw_n,
  input logic           ior_n,
  input logic           iow_n,
  input logic [NCH-1:0] dack,
  input logic           tc_n
);
  // R3
  bus_released_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_req |-> (!aen && !addr_oe && !data_oe && dack == '0 && memr_n && memw_n && ior_n && iow_n));

  // R2
  grant_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(aen) |-> $past(hold_ack) && hold_req);

  // R4
  one_dack_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dack));

  // R5
  no_read_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(!memr_n && !ior_n) && !(!memw_n && !iow_n));

  // R7
  stretch_chk: assert property (@(posedge clk) disable iff (rst)
    (!(memr_n && memw_n) && !rdy && eop_in_n) |=> ($stable(memr_n) && $stable(memw_n) && $stable(ior_n) && $stable(iow_n)));

  // R8
  stb_drives_bus_chk: assert property (@(posedge clk) disable iff (rst)
    adstb |-> (aen && data_oe && memr_n && memw_n));

  // R10
  tc_single_chk: assert property (@(posedge clk) disable iff (rst)
    !tc_n |-> (!hold_req ##1 tc_n));

  // R11
  eop_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (aen && !eop_in_n) |=> (!hold_req && !aen && tc_n));
endmodule

bind dma_cycle_seq dma_seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .hold_ack(hold_ack), .rdy(rdy), .eop_in_n(eop_in_n),
  .hold_req(hold_req), .aen(aen), .adstb(adstb), .addr_oe(addr_oe), .data_oe(data_oe),
  .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .dack(dack), .tc_n(tc_n)
);

// File: tb/test_dma_cycle_seq.sv
module test_dma_cycle_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, svc_req, addr_dec, hold_ack, rdy, eop_in_n;
  logic [1:0] svc_chan, svc_mode;
  logic [15:0] base_addr, dest_addr, xfer_len;
  logic [7:0] data_in;
  logic hold_req, aen, adstb, addr_oe, data_oe, memr_n, memw_n, ior_n, iow_n, tc_n;
  logic [7:0] addr_lo, data_out;
  logic [3:0] dack;

  dma_cycle_seq i_dma_cycle_seq (.*);

  int checks = 0, failures = 0;
  bit started = 0, done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference model
  int ms, mmode, mch, mbase, mdest, mrem, mup, mtmp;
  bit mdec, mwr, mupv, mtc;

  function automatic int m_cur();
    return (mmode == 3 && mwr) ? mdest : mbase;
  endfunction
  function automatic bit m_stb();
    return ms == 2 && (!mupv || ((m_cur() >> 8) != mup));
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      ms = 0; mmode = 0; mch = 0; mwr = 0; mupv = 0; mtc = 0; mtmp = 0;
      mbase = 0; mdest = 0; mrem = 0; mup = 0; mdec = 0;
    end else begin
      mtc = 0;
      case (ms)
        0: if (svc_req && svc_mode != 0) begin
          mmode = svc_mode; mch = svc_chan; mbase = base_addr; mdest = dest_addr;
          mrem = xfer_len; mdec = addr_dec; mupv = 0; mwr = 0; ms = 1;
        end
        1: if (hold_ack) ms = 2;
        2: begin
          if (m_stb()) begin mupv = 1; mup = m_cur() >> 8; end
          ms = eop_in_n ? 3 : 0;
        end
        default: begin
          if (!eop_in_n) ms = 0;
          else if (rdy) begin
            if (mmode == 3 && !mwr) begin mtmp = data_in; mwr = 1; ms = 2; end
            else begin
              mwr = 0;
              if (mrem == 0) begin ms = 0; mtc = 1; end
              else begin
                mrem--;
                mbase = (mdec ? mbase - 1 : mbase + 1) & 16'hFFFF;
                mdest = (mdec ? mdest - 1 : mdest + 1) & 16'hFFFF;
                ms = 2;
              end
            end
          end
        end
      endcase
    end
  end

  always @(negedge clk) if (started && !done) begin
    bit act, strb, m2w;
    int cur;
    act = ms >= 2; strb = ms == 3; cur = m_cur();
    m2w = strb && mmode == 3 && mwr;
    chk("R2 hold_req", hold_req, ms != 0);
    chk("R3 aen/addr_oe", {aen, addr_oe}, {act, act});
    chk("R9 addr_lo", addr_lo, act ? (cur & 255) : 0);
    chk("R8 adstb", adstb, m_stb());
    chk("R8 data_oe", data_oe, m_stb() || m2w);
    chk("R6 data_out", data_out, m_stb() ? (cur >> 8) : (m2w ? mtmp : 0));
    chk("R4 memr_n/iow_n", {memr_n, iow_n},
        {!(strb && (mmode == 1 || (mmode == 3 && !mwr))), !(strb && mmode == 1)});
    chk("R5 ior_n/memw_n", {ior_n, memw_n},
        {!(strb && mmode == 2), !(strb && (mmode == 2 || m2w))});
    chk("R4 dack", dack, (act && mmode != 3) ? (1 << mch) : 0);
    chk("R10 tc_n", tc_n, !mtc);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_to_idle();
    while (hold_req) step(1);
  endtask

  initial begin
    rst = 1; svc_req = 0; svc_chan = 0; svc_mode = 0; addr_dec = 0; hold_ack = 0;
    rdy = 1; eop_in_n = 1; data_in = 0; base_addr = 0; dest_addr = 0; xfer_len = 0;
    step(3);
    chk("R3 reset state", {hold_req, aen, data_oe, dack, tc_n}, {3'b000, 4'b0000, 1'b1});
    rst = 0;
    step(1);

    // R1: requests with no mode, then mode with no request
    svc_req = 1; svc_mode = 0; step(3);
    svc_req = 0; svc_mode = 1; step(3);
    chk("R1 ignored request", hold_req, 1'b0);

    // memory to I/O, counting up across a page, slow grant, eop ignored while waiting
    svc_chan = 2; base_addr = 16'h12FE; xfer_len = 3; addr_dec = 0; svc_mode = 1;
    svc_req = 1; step(1); svc_req = 0;
    eop_in_n = 0; step(1); eop_in_n = 1; step(2);
    chk("R2 waiting for grant", {hold_req, aen}, 2'b10);
    chk("R11 eop ignored in hold", hold_req, 1'b1);
    hold_ack = 1; step(3);
    rdy = 0; step(2);
    chk("R7 strobe stretched", {memr_n, iow_n, dack[2]}, 3'b001);
    rdy = 1;
    run_to_idle();
    hold_ack = 0;
    step(2);

    // I/O to memory, counting down across a page
    svc_chan = 0; base_addr = 16'h2001; xfer_len = 2; addr_dec = 1; svc_mode = 2;
    svc_req = 1; step(1); svc_req = 0; step(1);
    hold_ack = 1;
    run_to_idle();
    hold_ack = 0;
    step(2);

    // memory to memory between two pages
    base_addr = 16'h4000; dest_addr = 16'h5000; xfer_len = 1; addr_dec = 0; svc_mode = 3;
    data_in = 8'hA5;
    svc_req = 1; hold_ack = 1; step(1); svc_req = 0;
    while (memw_n) step(1);
    chk("R6 first byte written", {data_oe, data_out}, {1'b1, 8'hA5});
    data_in = 8'h3C;
    while (!memw_n) step(1);
    rdy = 0;
    while (memr_n) step(1);
    step(2); rdy = 1;
    while (memw_n) step(1);
    chk("R6 second byte written", {data_oe, data_out}, {1'b1, 8'h3C});
    run_to_idle();
    step(2);

    // external end of process mid transfer
    svc_chan = 1; base_addr = 16'h0100; xfer_len = 5; addr_dec = 0; svc_mode = 1;
    svc_req = 1; step(1); svc_req = 0;
    step(5);
    eop_in_n = 0; step(1);
    chk("R11 aborted by eop", {hold_req, aen, tc_n}, 3'b001);
    eop_in_n = 1; step(2);
    chk("R11 stays idle", hold_req, 1'b0);
    hold_ack = 0;
    step(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule